// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

A synchronous controller for a single-slot gum dispenser. Each clock it samples two coin strobes, one for a nickel and one for a dime. Each strobe is high for exactly one clock per coin. The controller keeps a running credit of 0, 5, 10 or 15 cents. When the credit reaches 15 cents it raises a release output. No change is given. Any coin that would push the credit past 15 cents, such as a dime arriving at 10 cents, also ends at 15. The 15-cent state holds the release output high until reset.

The credit is held in a two-bit register coded Q1Q0: 00 means 0 cents, 01 means 5, 10 means 10 and 11 means 15. A compile-time parameter picks how the next state is formed. One choice uses direct D-register equations. The other uses JK-style set/keep terms. Both choices must give the same cycle-by-cycle behaviour. If both strobes are high in the same cycle, the controller treats it as no coin and holds the credit.

Top module: `vend_ctrl`

## Requirements
- R1: While rst_ni is low, the credit is 0 cents (Q1Q0 = 00) and open_o is 0. Credit starts from 0 after reset is released.
- R2: A nickel alone (nickel_i=1, dime_i=0) moves the credit 0→5, 5→10 and 10→15 cents at the next rising clock edge.
- R3: A dime alone moves the credit 0→10 cents. From 5 or 10 cents, a dime alone moves the credit to 15 cents.
- R4: In a cycle with neither strobe high, the credit does not change.
- R5: In a cycle with both strobes high, the credit does not change.
- R6: open_o is 1 exactly when the credit is 15 cents (Q1Q0 = 11). It depends only on the registered state and changes only after a clock edge or a reset.
- R7: Once the credit is 15 cents, it stays at 15 for every strobe combination until reset.
- R8: The D-equation form (FORM = FORM_D) and the JK form (FORM = FORM_JK) produce the same open_o sequence for the same inputs.
- R9: Reset is asynchronous: open_o falls when rst_ni falls, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nickel_i | input | 1 | One-cycle strobe for a 5-cent coin |
| dime_i | input | 1 | One-cycle strobe for a 10-cent coin |
| open_o | output | 1 | Release request, high at 15-cent credit |

## Verification
Two things can happen in the same cycle: a coin can be credited while a second strobe is high, and a coin can arrive while the controller is already in the saturated 15-cent state. The bench provokes the first with directed and random cycles that raise both strobes. The credit must hold, and this is judged later: only the number of further coins needed to raise open_o shows that the credit did not move. The second is provoked by sending more coins after open_o is high. Every such cycle must keep open_o high until a reset arrives, in both next-state forms side by side.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    CR_0  = 2'b00,
    CR_5  = 2'b01,
    CR_10 = 2'b10,
    CR_15 = 2'b11
  } credit_e;

  typedef enum logic {
    FORM_D  = 1'b0,
    FORM_JK = 1'b1
  } next_form_e;

  localparam int unsigned CreditW = 2;
endpackage

// File: rtl/vend_coin_qual.sv
// Both strobes high at once counts as no coin.
module vend_coin_qual (
  input  logic nickel_i,
  input  logic dime_i,
  output logic nickel_o,
  output logic dime_o
);
  always_comb begin
    nickel_o = nickel_i & ~dime_i;
    dime_o   = dime_i & ~nickel_i;
  end
endmodule

// File: rtl/vend_next_d.sv
module vend_next_d
  import vend_pkg::*;
(
  input  logic [CreditW-1:0] q_i,
  input  logic               n_i,
  input  logic               d_i,
  output logic [CreditW-1:0] q_next_o
);
  logic q1, q0;
  always_comb begin
    q1 = q_i[1];
    q0 = q_i[0];
    q_next_o[1] = q1 | d_i | (q0 & n_i);
    q_next_o[0] = (n_i & ~q0) | (q0 & ~n_i) | (q1 & n_i) | (q1 & d_i);
  end
endmodule

// File: rtl/vend_next_jk.sv
module vend_next_jk
  import vend_pkg::*;
(
  input  logic [CreditW-1:0] q_i,
  input  logic               n_i,
  input  logic               d_i,
  output logic [CreditW-1:0] q_next_o
);
  logic q1, q0;
  logic j1, k1, j0, k0;
  always_comb begin
    q1 = q_i[1];
    q0 = q_i[0];
    j1 = d_i | (q0 & n_i);
    k1 = 1'b0;
    j0 = (~q0 & n_i) | (q1 & d_i);
    k0 = ~q1 & n_i;  // clear low bit only on 5 -> 10
    q_next_o[1] = (j1 & ~q1) | (~k1 & q1);
    q_next_o[0] = (j0 & ~q0) | (~k0 & q0);
  end
endmodule

// File: rtl/vend_state_reg.sv
module vend_state_reg
  import vend_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CreditW-1:0] d_i,
  output logic [CreditW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= CR_0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter next_form_e FORM = FORM_D
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  logic               n_q, d_q;
  logic [CreditW-1:0] credit_q, credit_d;

  vend_coin_qual u_qual (
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .nickel_o (n_q),
    .dime_o   (d_q)
  );

  generate
    if (FORM == FORM_JK) begin : g_jk
      vend_next_jk u_next (
        .q_i      (credit_q),
        .n_i      (n_q),
        .d_i      (d_q),
        .q_next_o (credit_d)
      );
    end else begin : g_d
      vend_next_d u_next (
        .q_i      (credit_q),
        .n_i      (n_q),
        .d_i      (d_q),
        .q_next_o (credit_d)
      );
    end
  endgenerate

  vend_state_reg u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (credit_d),
    .q_o    (credit_q)
  );

  assign open_o = credit_q[1] & credit_q[0];
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic nickel_i,
  input logic dime_i,
  input logic open_o
);
  p_sticky_open_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> open_o);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nickel_i && !dime_i) |=> $stable(open_o));

  p_both_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nickel_i && dime_i) |=> $stable(open_o));

  p_rise_needs_coin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(nickel_i ^ dime_i));
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .nickel_i (nickel_i),
  .dime_i   (dime_i),
  .open_o   (open_o)
);

// File: tb/vend_ctrl_test.sv
module vend_ctrl_test;
  import vend_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic nick = 1'b0, dime = 1'b0;
  logic open_d, open_jk;
  int   checks = 0, errors = 0;
  int   cred = 0;  // bench model, cents

  always #(CLK_PERIOD/2) clk = ~clk;

  vend_ctrl #(.FORM(FORM_D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .nickel_i(nick), .dime_i(dime), .open_o(open_d));
  vend_ctrl #(.FORM(FORM_JK)) uut_jk (
    .clk_i(clk), .rst_ni(rst_n), .nickel_i(nick), .dime_i(dime), .open_o(open_jk));

  function automatic int next_cred(int c, bit n, bit d);
    if (c == 15 || (n && d) || (!n && !d)) return c;
    if (n) return (c + 5 > 15) ? 15 : c + 5;
    return (c + 10 > 15) ? 15 : c + 10;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s open actual=%b expected=%b (credit %0d)", req, act, exp, cred);
    end
  endtask

  task automatic check_both(string req);
    check(req, open_d, cred == 15);
    check({req, "/R8"}, open_jk, open_d);
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(bit n, bit d, string req);
    nick = n; dime = d;
    @(posedge clk);
    cred = next_cred(cred, n, d);
    @(negedge clk);
    nick = 0; dime = 0;
    check_both(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    cred = 0;
    check("R9", open_d, 1'b0);
    check("R9", open_jk, 1'b0);
    @(negedge clk);
    check_both("R1");
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #2 rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    check_both("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_both("R1");
    // three nickels: R2
    step(1,0,"R2"); step(1,0,"R2"); step(1,0,"R2");
    step(0,0,"R7"); step(1,0,"R7"); step(0,1,"R7"); step(1,1,"R7");
    do_reset();
    // nickel then dime: R3
    step(1,0,"R2"); step(0,0,"R4"); step(0,1,"R3");
    do_reset();
    // dime then nickel
    step(0,1,"R3"); step(1,0,"R2");
    do_reset();
    // two dimes, overshoot saturates
    step(0,1,"R3"); step(0,1,"R3"); step(0,1,"R7");
    do_reset();
    // two nickels then a dime
    step(1,0,"R2"); step(1,0,"R2"); step(0,1,"R3");
    do_reset();
    // both strobes hold: 10 cents then both, then nickel must finish
    step(0,1,"R3"); step(1,1,"R5"); step(1,1,"R5"); step(0,0,"R4");
    step(1,0,"R5");
    do_reset();
    // both from 5: must still need a nickel plus nickel (not 15 yet)
    step(1,0,"R2"); step(1,1,"R5"); step(1,0,"R5"); step(1,0,"R6");
    do_reset();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) do_reset();
      else if (r < 40) step(0,0,"R4");
      else if (r < 65) step(1,0,"R2");
      else if (r < 90) step(0,1,"R3");
      else step(1,1,"R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule